// File: doc/BRIEF.md
# Codec Serial Configuration Master

This block brings up a write-only audio codec after reset by playing a fixed list of register writes over a two-wire serial control bus. It makes the clock line from a divided system clock and drives the data line in open-drain fashion: a 0 on `sda_o` pulls the line low, a 1 releases it. It reads the wired line back on `sda_i` to see the acknowledge bits.

Each register write is its own transaction. A transaction has a start condition, three bytes each followed by an acknowledge slot, and a stop condition. The first byte is the device address with the write bit. The second byte holds a 7-bit register address and the top bit of a 9-bit value. The third byte holds the low eight bits of that value. A pulse on `start_i` plays the whole list. `done_o` reports a clean finish. A missing acknowledge stops the run and raises `err_o`.

Top module: `codec_cfg_master`

## Requirements
- R1: While reset is held and until the first start pulse, `scl_o` and `sda_o` are 1 and `busy_o`, `done_o` and `err_o` are 0.
- R2: Each transaction opens with a start condition (data falls while clock is high) and closes with a stop condition (data rises while clock is high). A complete transaction has exactly 28 clock rising edges in between: 27 bit slots plus one that comes just before the stop.
- R3: The first byte is 0x68, which is device address 0x34 followed by write bit 0. Every byte goes out MSB first.
- R4: The second byte is {register[6:0], value[8]} and the third byte is value[7:0].
- R5: The writes go out in this order (register <- 9-bit value): 0x0F <- 0x000 (reset), 0x06 <- 0x000 (power-down cleared), 0x04 <- 0x014 (microphone routed to the ADC), 0x07 <- 0x042 (codec is clock master, bit 6), 0x08 <- 0x00E (word 16'h100E: normal mode, 8 kHz ADC), 0x09 <- 0x001 (activate).
- R6: During a transaction the data line changes only while the clock is low. The only exceptions are the start and stop conditions.
- R7: During every ninth bit slot the master releases data (`sda_o` = 1). A low line in that slot counts as an acknowledge.
- R8: If an acknowledge slot reads high, the block sends no further bytes and no further writes. It issues a stop condition, sets `err_o`, keeps `done_o` at 0 and drops `busy_o`.
- R9: After the last write is acknowledged, `done_o` goes to 1, `busy_o` goes to 0 and `err_o` stays 0.
- R10: A start pulse while the block is busy is ignored. A start pulse while the block is idle clears `done_o` and `err_o` and replays the list from the first write.
- R11: Inside a transaction, consecutive clock rising edges are 4*CLK_DIV system clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts the init sequence when idle |
| sda_i | input | 1 | Wired data line read back |
| scl_o | output | 1 | Serial clock line |
| sda_o | output | 1 | Data drive: 0 pulls low, 1 releases |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last run finished with every write acknowledged |
| err_o | output | 1 | Last run stopped on a missing acknowledge |

## Verification
A bus-level slave model decodes each transaction and acknowledges it. One run has every slot acknowledged and compares all six frames with byte values worked out from the register/value list. That run shows whether the packing, the bit order and the list order are right. A sweep then withholds the acknowledge at each of the 18 byte positions in turn. Each of these runs must end in a stop with exactly 9*(byte+1)+1 clock edges, which shows that the abort happens at the right place and nothing leaks past it. A start pulse issued in the middle of a run tells a replay apart from an ignored start. A final clean run after an error shows that the flags clear.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;
  localparam int unsigned N_WRITES = 6;
  localparam int unsigned IDX_W    = 3;
  localparam int unsigned FRAME_W  = 24;

  typedef enum logic [2:0] {LK_IDLE, LK_START, LK_BIT, LK_ACK, LK_STOP} link_state_e;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LAUNCH, SQ_WAIT} seq_state_e;

  // {reg[6:0], value[8:0]}
  function automatic logic [15:0] init_word(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    init_word = {7'h0f, 9'h000};
      3'd1:    init_word = {7'h06, 9'h000};
      3'd2:    init_word = {7'h04, 9'h014};
      3'd3:    init_word = {7'h07, 9'h042};
      3'd4:    init_word = 16'h100e;
      3'd5:    init_word = {7'h09, 9'h001};
      default: init_word = 16'h0000;
    endcase
  endfunction
endpackage

// File: rtl/cfg_init_rom.sv
module cfg_init_rom
  import codec_cfg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h34
) (
  input  logic [IDX_W-1:0]   idx_i,
  output logic [FRAME_W-1:0] frame_o
);
  // write-only device: R/W bit fixed to 0
  assign frame_o = {DEV_ADDR, 1'b0, init_word(idx_i)};
endmodule

// File: rtl/cfg_quarter_timer.sv
module cfg_quarter_timer #(
  parameter int unsigned DIV = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  a_r11_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o)
    else $error("R11: back-to-back quarter ticks");
endmodule

// File: rtl/cfg_link_fsm.sv
module cfg_link_fsm
  import codec_cfg_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               go_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               tick_i,
  input  logic               sda_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               nack_o,
  output logic               scl_o,
  output logic               sda_o
);
  link_state_e        state_q;
  logic [1:0]         qtr_q;
  logic [2:0]         bit_q;
  logic [1:0]         byte_q;
  logic [FRAME_W-1:0] sh_q;
  logic               nack_q, done_q, hold_q;
  logic [1:0]         sync_q;
  logic               sda_s, scl_c, sda_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], sda_i};
  end
  assign sda_s = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_IDLE;
      qtr_q   <= '0;
      bit_q   <= 3'd7;
      byte_q  <= '0;
      sh_q    <= '0;
      nack_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (state_q == LK_IDLE) begin
        if (go_i) begin
          state_q <= LK_START;
          qtr_q   <= '0;
          bit_q   <= 3'd7;
          byte_q  <= '0;
          sh_q    <= frame_i;
          nack_q  <= 1'b0;
        end
      end else if (tick_i) begin
        qtr_q <= qtr_q + 2'd1;
        if (qtr_q == 2'd3) begin
          unique case (state_q)
            LK_START: state_q <= LK_BIT;
            LK_BIT: begin
              sh_q <= sh_q << 1;
              if (bit_q == 3'd0) state_q <= LK_ACK;
              else               bit_q   <= bit_q - 3'd1;
            end
            LK_ACK: begin
              bit_q <= 3'd7;
              if (sda_s) begin
                nack_q  <= 1'b1;
                state_q <= LK_STOP;
              end else if (byte_q == 2'd2) begin
                state_q <= LK_STOP;
              end else begin
                byte_q  <= byte_q + 2'd1;
                state_q <= LK_BIT;
              end
            end
            LK_STOP: begin
              state_q <= LK_IDLE;
              done_q  <= 1'b1;
            end
            default: state_q <= LK_IDLE;
          endcase
        end
      end
    end
  end

  // quarter 0 of a slot holds data so it never moves on a clock edge
  always_comb begin
    scl_c = 1'b1;
    sda_c = 1'b1;
    unique case (state_q)
      LK_START: begin scl_c = (qtr_q != 2'd3); sda_c = (qtr_q == 2'd0); end
      LK_BIT:   begin scl_c = qtr_q[1]; sda_c = (qtr_q == 2'd0) ? hold_q : sh_q[FRAME_W-1]; end
      LK_ACK:   begin scl_c = qtr_q[1]; sda_c = (qtr_q == 2'd0) ? hold_q : 1'b1; end
      LK_STOP:  begin scl_c = qtr_q[1]; sda_c = (qtr_q == 2'd0) ? hold_q : (qtr_q == 2'd3); end
      default:  begin scl_c = 1'b1; sda_c = 1'b1; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_q <= 1'b1;
    else         hold_q <= sda_c;
  end

  assign scl_o  = scl_c;
  assign sda_o  = sda_c;
  assign busy_o = (state_q != LK_IDLE);
  assign done_o = done_q;
  assign nack_o = nack_q;

  a_r6_data_on_low_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_o && $past(scl_o) && (sda_o != $past(sda_o))) |->
      ((state_q == LK_START && qtr_q == 2'd1) || (state_q == LK_STOP && qtr_q == 2'd3)))
    else $error("R6: data moved while clock high");

  a_r8_nack_to_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && state_q == LK_ACK && qtr_q == 2'd3 && sda_s) |=> (state_q == LK_STOP && nack_q))
    else $error("R8: missing acknowledge not followed by stop");

  a_r2_go_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> (state_q == LK_IDLE))
    else $error("R2: launch while transaction open");
endmodule

// File: rtl/codec_cfg_master.sv
module codec_cfg_master
  import codec_cfg_pkg::*;
#(
  parameter int unsigned CLK_DIV  = 125,
  parameter logic [6:0]  DEV_ADDR = 7'h34
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic busy_o,
  output logic done_o,
  output logic err_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WRITES - 1);

  seq_state_e         sq_q;
  logic [IDX_W-1:0]   idx_q;
  logic               done_q, err_q;
  logic [FRAME_W-1:0] frame;
  logic               go, tick, lk_busy, lk_done, lk_nack;

  cfg_init_rom #(.DEV_ADDR(DEV_ADDR)) u_rom (
    .idx_i   (idx_q),
    .frame_o (frame)
  );

  cfg_quarter_timer #(.DIV(CLK_DIV)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (lk_busy),
    .tick_o (tick)
  );

  cfg_link_fsm u_link (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .frame_i (frame),
    .tick_i  (tick),
    .sda_i   (sda_i),
    .busy_o  (lk_busy),
    .done_o  (lk_done),
    .nack_o  (lk_nack),
    .scl_o   (scl_o),
    .sda_o   (sda_o)
  );

  assign go = (sq_q == SQ_LAUNCH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_q   <= SQ_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      unique case (sq_q)
        SQ_IDLE: if (start_i) begin
          idx_q  <= '0;
          done_q <= 1'b0;
          err_q  <= 1'b0;
          sq_q   <= SQ_LAUNCH;
        end
        SQ_LAUNCH: sq_q <= SQ_WAIT;
        SQ_WAIT: if (lk_done) begin
          if (lk_nack) begin
            err_q <= 1'b1;
            sq_q  <= SQ_IDLE;
          end else if (idx_q == LAST_IDX) begin
            done_q <= 1'b1;
            sq_q   <= SQ_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            sq_q  <= SQ_LAUNCH;
          end
        end
        default: sq_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o = (sq_q != SQ_IDLE);
  assign done_o = done_q;
  assign err_o  = err_q;

  a_r8_flags_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o))
    else $error("R8: done and error together");

  a_r9_end_reports: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o || err_o))
    else $error("R9: run ended with no outcome flag");

  a_r10_start_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (busy_o && !done_o && !err_o))
    else $error("R10: start from idle did not restart");
endmodule

// File: tb/codec_cfg_master_test.sv
`timescale 1ns/1ps
module codec_cfg_master_test;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, slave_pull = 1'b0;
  logic scl, sda_drv, busy, done, err;
  wire  line = sda_drv & ~slave_pull;

  always #10 clk = ~clk;

  codec_cfg_master #(.CLK_DIV(DIV), .DEV_ADDR(7'h34)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sda_i(line),
    .scl_o(scl), .sda_o(sda_drv), .busy_o(busy), .done_o(done), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  int exp_reg [6] = '{15, 6, 4, 7, 8, 9};
  int exp_val [6] = '{0, 0, 'h14, 'h42, 'h0e, 1};

  // bus monitor / slave
  logic [31:0] fr_sh [128], fr_rel [128];
  int fr_rises [128], fr_per [128];
  int n_frames = 0, illegal = 0, nack_frame = -1, nack_byte = 0;
  int cyc = 0, last_rise = 0, rises = 0, per_bad = 0;
  logic [31:0] sh = 0, rel = 0;
  logic in_frame = 0, prev_scl = 1, prev_line = 1;

  always @(negedge clk) begin
    cyc++;
    if (prev_scl && scl && prev_line && !line) begin
      if (in_frame) illegal++;
      in_frame = 1; rises = 0; sh = 0; rel = 0; per_bad = 0;
    end else if (prev_scl && scl && !prev_line && line && in_frame) begin
      if (n_frames < 128) begin
        fr_sh[n_frames] = sh; fr_rel[n_frames] = rel;
        fr_rises[n_frames] = rises; fr_per[n_frames] = per_bad;
      end
      n_frames++;
      in_frame = 0;
    end
    if (in_frame && !prev_scl && scl) begin
      rises++;
      sh  = {sh[30:0], line};
      rel = {rel[30:0], sda_drv};
      if (rises > 1 && (cyc - last_rise) != 4*DIV) per_bad++;
      last_rise = cyc;
    end
    if (in_frame && prev_scl && !scl) begin
      if (rises == 8 || rises == 17 || rises == 26)
        slave_pull = !(nack_frame == n_frames && nack_byte == rises/9);
      else if (rises == 9 || rises == 18 || rises == 27)
        slave_pull = 0;
    end
    prev_scl = scl; prev_line = line;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic run_seq(input int nt, input int nb, input bit poke);
    int base, ne, er, n, got, wait_c;
    logic [31:0] s, r;
    base = n_frames;
    nack_frame = (nt < 0) ? -1 : base + nt;
    nack_byte  = nb;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    @(negedge clk);
    check(busy && !done && !err, "R10 start from idle", {busy, done, err}, 3'b100);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1; @(negedge clk) start = 0;
    end
    wait_c = 0;
    while (busy && wait_c < 30000) begin @(negedge clk); wait_c++; end
    check(!busy, "R9 run completes", busy, 0);
    ne = (nt < 0) ? 6 : nt + 1;
    check(n_frames - base == ne, "R2/R8 transaction count", n_frames - base, ne);
    for (int k = 0; k < ne && k < n_frames - base; k++) begin
      er = (nt >= 0 && k == ne - 1) ? 9*(nb+1) + 1 : 28;
      check(fr_rises[base+k] == er, "R2 clock edges per transaction", fr_rises[base+k], er);
      check(fr_per[base+k] == 0, "R11 clock period", fr_per[base+k], 0);
      n = er - 1;
      s = fr_sh[base+k] >> 1;
      r = fr_rel[base+k] >> 1;
      for (int j = 0; j < 3 && 9*j + 9 <= n; j++) begin
        got = int'((s >> (n - 9*j - 8)) & 32'hff);
        if (j == 0) check(got == 'h68, "R3 address byte", got, 'h68);
        if (j == 1) check(got == exp_reg[k]*2 + exp_val[k]/256, "R4/R5 second byte", got, exp_reg[k]*2 + exp_val[k]/256);
        if (j == 2) check(got == exp_val[k] % 256, "R4/R5 third byte", got, exp_val[k] % 256);
        check(((r >> (n - 9*j - 9)) & 1) == 1, "R7 master releases ack slot", int'((r >> (n - 9*j - 9)) & 1), 1);
      end
    end
    if (nt < 0) check(done && !err, "R9 done flag", {done, err}, 2'b10);
    else        check(err && !done, "R8 error flag", {done, err}, 2'b01);
    check(scl && sda_drv, "R8 bus released at end", {scl, sda_drv}, 2'b11);
    check(illegal == 0, "R6 no start inside transaction", illegal, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(scl && sda_drv && !busy && !done && !err, "R1 reset state", {scl, sda_drv, busy, done, err}, 5'b11000);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(scl && sda_drv && !busy && !done && !err, "R1 idle after reset", {scl, sda_drv, busy, done, err}, 5'b11000);
    run_seq(-1, 0, 1);
    for (int t = 0; t < 6; t++)
      for (int b = 0; b < 3; b++)
        run_seq(t, b, 0);
    run_seq(-1, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule